// File: doc/BRIEF.md
# Two-Level Trap Delegation Controller

This block decides, for every trap a core takes, which privilege level services it: machine (M), hypervisor-supervisor (HS) or virtual supervisor (VS). It first consults the machine delegation masks. If the trap is delegated below M and the hypervisor option is built in, it then consults the hypervisor delegation masks to choose between HS and VS. Environment calls arrive under one cause number, and the block renames them according to the mode that issued them.

The block also computes the new machine and hypervisor status words. These cover the saved interrupt enables, the previous privilege, and two stacked levels of previous-virtualisation and previous-privilege bits. It reports the target mode, the next virtualisation and force-HS flags, and a strobe that tells the register file to swap its guest and host banks. The block accepts a request in any cycle and never applies back-pressure. A request is one cycle of `trap_valid`, and its results appear together on the next clock edge, flagged by `trap_taken`. The CSR file reads the current status words through `mstat_in` and `hstat_in` and writes back the results.

Top module: `hv_trap_deleg`

## Requirements
- R1: A synchronous trap with cause 8 (environment call) is reported on `cause_out` as 8 from U (priv 0), 9 from S (priv 1) with `virt_on` low, 10 from S with `virt_on` high, and 11 from M (priv 3). All other causes pass through unchanged.
- R2: A trap targets S (`trap_mode`=1) only when all of the following hold: `cur_priv` is 0 or 1, the final cause is below XLEN, and the bit at that cause index is set in `m_irq_deleg` (when `trap_async` is high) or in `m_exc_deleg` (when `trap_async` is low). Otherwise it targets M (`trap_mode`=3).
- R3: An S-level trap stays in the guest (`virt_next`=1) only when all of these hold: `virt_on` is high, the cause bit is set in `h_irq_deleg` or `h_exc_deleg` (selected by `trap_async`), and `force_hs` is low. In that case `hstat_out` equals `hstat_in` and there is no swap.
- R4: An S-level trap that leaves a guest for HS has these effects. It raises `swap_strobe`. It sets sp2v (hstat bit 1) to the old spv (hstat bit 0) and sp2p (hstat bit 2) to the old spp (mstat bit 4). It sets spv to 1 and stl (hstat bit 3) to `force_hs`. It drives `virt_next` and `force_hs_next` to 0.
- R5: An S-level trap taken with `virt_on` low updates sp2v, sp2p and spv as in R4, with spv set to 0. It leaves stl and `force_hs_next` unchanged and gives no swap.
- R6: An M-level trap raises `swap_strobe` exactly when `virt_on` is high. It sets mpv (mstat bit 7) to `virt_on` and mtl (mstat bit 8) to `force_hs`, and drives `virt_next` to 0.
- R7: On S entry, spie (mstat bit 2) takes sie (bit 0), spp (bit 4) takes `cur_priv[0]`, and sie clears. On M entry, mpie (bit 3) takes mie (bit 1), mpp (bits 6:5) takes `cur_priv`, and mie clears. Other status bits are unchanged.
- R8: All results are registered and appear on the edge that samples `trap_valid` high. A cycle without `trap_valid` lowers `trap_taken` and `swap_strobe` and holds every other output.
- R9: After reset, `trap_mode` is 3 and every other output is 0.
- R10: With the hypervisor option disabled (HV=0), the target is chosen from the machine masks alone. `hstat_out`, mpv, mtl, `virt_next`, `force_hs_next` and `swap_strobe` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request, one cycle per trap |
| trap_async | input | 1 | 1 for an interrupt, 0 for an exception |
| trap_cause | input | CW | Raw cause code |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_on | input | 1 | Virtualisation currently on |
| force_hs | input | 1 | Force trap into HS |
| m_exc_deleg | input | XLEN | Machine exception delegation mask |
| m_irq_deleg | input | XLEN | Machine interrupt delegation mask |
| h_exc_deleg | input | XLEN | Hypervisor exception delegation mask |
| h_irq_deleg | input | XLEN | Hypervisor interrupt delegation mask |
| mstat_in | input | 9 | Current machine status bits |
| hstat_in | input | 4 | Current hypervisor status bits |
| trap_taken | output | 1 | Results below belong to a trap just taken |
| trap_mode | output | 2 | Target privilege (1 S, 3 M) |
| virt_next | output | 1 | Virtualisation after the trap |
| force_hs_next | output | 1 | Force-HS flag after the trap |
| swap_strobe | output | 1 | Swap guest and host register banks |
| cause_out | output | CW | Final cause code |
| mstat_out | output | 9 | Machine status after the trap |
| hstat_out | output | 4 | Hypervisor status after the trap |

## Verification
Every result of a trap is due one clock edge after `trap_valid` is sampled high, with no longer path. So the bench changes inputs on the falling edge, lets one rising edge pass, and compares all outputs on the following falling edge against a model of the requirements. The bench also runs idle cycles with fresh inputs to confirm that the outputs hold and that the pulses drop one edge after the request goes away.

// File: rtl/hv_trap_pkg.sv
package hv_trap_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;
  localparam int ECALL_CODE = 8;

  typedef struct packed {
    logic       mtl;
    logic       mpv;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } mstat_t;

  typedef struct packed {
    logic stl;
    logic sp2p;
    logic sp2v;
    logic spv;
  } hstat_t;
endpackage

// File: rtl/hv_trap_cause.sv
module hv_trap_cause
  import hv_trap_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          is_async,
  input  logic [CW-1:0] cause_raw,
  input  logic [1:0]    priv,
  input  logic          virt,
  output logic [CW-1:0] cause_fin
);
  always_comb begin
    cause_fin = cause_raw;
    if (!is_async && cause_raw == CW'(ECALL_CODE)) begin
      unique case (priv)
        PRV_M:   cause_fin = CW'(ECALL_CODE + 3);
        PRV_S:   cause_fin = virt ? CW'(ECALL_CODE + 2) : CW'(ECALL_CODE + 1);
        default: cause_fin = CW'(ECALL_CODE);
      endcase
    end
  end
endmodule

// File: rtl/hv_trap_route.sv
module hv_trap_route
  import hv_trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 6,
  parameter bit HV   = 1'b1
) (
  input  logic            is_async,
  input  logic [CW-1:0]   cause_fin,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            force_hs,
  input  logic [XLEN-1:0] m_exc,
  input  logic [XLEN-1:0] m_irq,
  input  logic [XLEN-1:0] h_exc,
  input  logic [XLEN-1:0] h_irq,
  output logic            to_s,
  output logic            to_vs
);
  localparam int IW = $clog2(XLEN);

  logic            in_range;
  logic [IW-1:0]   idx;
  logic [XLEN-1:0] m_sel;

  assign in_range = 32'(cause_fin) < 32'(XLEN);
  assign idx      = cause_fin[IW-1:0];
  assign m_sel    = is_async ? m_irq : m_exc;
  assign to_s     = (priv <= PRV_S) && in_range && m_sel[idx];

  generate
    if (HV) begin : g_hyp
      logic [XLEN-1:0] h_sel;
      assign h_sel = is_async ? h_irq : h_exc;
      assign to_vs = to_s && virt && h_sel[idx] && !force_hs;
    end else begin : g_flat
      logic unused_h;
      assign unused_h = ^{h_exc, h_irq, virt, force_hs};
      assign to_vs    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hv_trap_status.sv
module hv_trap_status
  import hv_trap_pkg::*;
#(
  parameter bit HV = 1'b1
) (
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       force_hs,
  input  logic       to_s,
  input  logic       to_vs,
  input  mstat_t     ms_in,
  input  hstat_t     hs_in,
  output mstat_t     ms_nx,
  output hstat_t     hs_nx,
  output logic [1:0] mode_nx,
  output logic       virt_nx,
  output logic       force_nx,
  output logic       swap_nx
);
  always_comb begin
    ms_nx    = ms_in;
    hs_nx    = hs_in;
    virt_nx  = virt;
    force_nx = force_hs;
    swap_nx  = 1'b0;
    if (to_s) begin
      mode_nx    = PRV_S;
      ms_nx.spie = ms_in.sie;
      ms_nx.spp  = priv[0];
      ms_nx.sie  = 1'b0;
      if (!to_vs) begin
        hs_nx.sp2v = hs_in.spv;
        hs_nx.sp2p = ms_in.spp;
        hs_nx.spv  = virt;
        if (virt) begin
          swap_nx   = 1'b1;
          hs_nx.stl = force_hs;
          force_nx  = 1'b0;
        end
        virt_nx = 1'b0;
      end
    end else begin
      mode_nx    = PRV_M;
      ms_nx.mpie = ms_in.mie;
      ms_nx.mpp  = priv;
      ms_nx.mie  = 1'b0;
      ms_nx.mpv  = virt;
      ms_nx.mtl  = force_hs;
      swap_nx    = virt;
      virt_nx    = 1'b0;
    end
    if (!HV) begin
      hs_nx     = '0;
      ms_nx.mpv = 1'b0;
      ms_nx.mtl = 1'b0;
      virt_nx   = 1'b0;
      force_nx  = 1'b0;
      swap_nx   = 1'b0;
    end
  end
endmodule

// File: rtl/hv_trap_deleg.sv
module hv_trap_deleg
  import hv_trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 6,
  parameter bit HV   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic            trap_async,
  input  logic [CW-1:0]   trap_cause,
  input  logic [1:0]      cur_priv,
  input  logic            virt_on,
  input  logic            force_hs,
  input  logic [XLEN-1:0] m_exc_deleg,
  input  logic [XLEN-1:0] m_irq_deleg,
  input  logic [XLEN-1:0] h_exc_deleg,
  input  logic [XLEN-1:0] h_irq_deleg,
  input  logic [8:0]      mstat_in,
  input  logic [3:0]      hstat_in,
  output logic            trap_taken,
  output logic [1:0]      trap_mode,
  output logic            virt_next,
  output logic            force_hs_next,
  output logic            swap_strobe,
  output logic [CW-1:0]   cause_out,
  output logic [8:0]      mstat_out,
  output logic [3:0]      hstat_out
);
  logic [CW-1:0] cause_fin;
  logic          to_s, to_vs;
  mstat_t        ms_nx;
  hstat_t        hs_nx;
  logic [1:0]    mode_nx;
  logic          virt_nx, force_nx, swap_nx;

  hv_trap_cause #(.CW(CW)) u_cause (
    .is_async (trap_async),
    .cause_raw(trap_cause),
    .priv     (cur_priv),
    .virt     (virt_on),
    .cause_fin(cause_fin)
  );

  hv_trap_route #(.XLEN(XLEN), .CW(CW), .HV(HV)) u_route (
    .is_async (trap_async),
    .cause_fin(cause_fin),
    .priv     (cur_priv),
    .virt     (virt_on),
    .force_hs (force_hs),
    .m_exc    (m_exc_deleg),
    .m_irq    (m_irq_deleg),
    .h_exc    (h_exc_deleg),
    .h_irq    (h_irq_deleg),
    .to_s     (to_s),
    .to_vs    (to_vs)
  );

  hv_trap_status #(.HV(HV)) u_status (
    .priv    (cur_priv),
    .virt    (virt_on),
    .force_hs(force_hs),
    .to_s    (to_s),
    .to_vs   (to_vs),
    .ms_in   (mstat_t'(mstat_in)),
    .hs_in   (hstat_t'(hstat_in)),
    .ms_nx   (ms_nx),
    .hs_nx   (hs_nx),
    .mode_nx (mode_nx),
    .virt_nx (virt_nx),
    .force_nx(force_nx),
    .swap_nx (swap_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_taken    <= 1'b0;
      trap_mode     <= PRV_M;
      virt_next     <= 1'b0;
      force_hs_next <= 1'b0;
      swap_strobe   <= 1'b0;
      cause_out     <= '0;
      mstat_out     <= '0;
      hstat_out     <= '0;
    end else if (trap_valid) begin
      trap_taken    <= 1'b1;
      trap_mode     <= mode_nx;
      virt_next     <= virt_nx;
      force_hs_next <= force_nx;
      swap_strobe   <= swap_nx;
      cause_out     <= cause_fin;
      mstat_out     <= ms_nx;
      hstat_out     <= hs_nx;
    end else begin
      trap_taken  <= 1'b0;
      swap_strobe <= 1'b0;
    end
  end

  p_swap_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_strobe |-> trap_taken);
  p_swap_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_strobe |-> $past(virt_on));
  p_guest_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    virt_next |-> trap_mode == PRV_S);
  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (trap_mode == PRV_S || trap_mode == PRV_M));
  p_mie_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && trap_mode == PRV_M) |-> (!mstat_out[1] && mstat_out[3] == $past(mstat_in[1])));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(trap_valid) |-> !trap_taken);

  generate
    if (HV) begin : g_hv_chk
      p_stl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && trap_mode == PRV_S && !virt_next && !$past(virt_on))
          |-> hstat_out[3] == $past(hstat_in[3]));
    end else begin : g_flat_chk
      p_flat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hstat_out == 4'd0 && !swap_strobe && !virt_next);
    end
  endgenerate
endmodule

// File: tb/hv_trap_deleg_bench.sv
`timescale 1ns/1ps
module hv_trap_deleg_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tv = 1'b0, ta = 1'b0, vo = 1'b0, fh = 1'b0;
  logic [5:0] tc = '0;
  logic [1:0] pr = '0;
  logic [31:0] me = '0, mi = '0, he = '0, hi = '0;
  logic [8:0] msi = '0;
  logic [3:0] hsi = '0;
  logic [24:0] out_a, out_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic a_tk, a_vn, a_fn, a_sw, b_tk, b_vn, b_fn, b_sw;
  logic [1:0] a_md, b_md;
  logic [5:0] a_c, b_c;
  logic [8:0] a_ms, b_ms;
  logic [3:0] a_hs, b_hs;

  hv_trap_deleg u_hv_trap_deleg (
    .clk(clk), .rst_n(rst_n), .trap_valid(tv), .trap_async(ta), .trap_cause(tc),
    .cur_priv(pr), .virt_on(vo), .force_hs(fh), .m_exc_deleg(me), .m_irq_deleg(mi),
    .h_exc_deleg(he), .h_irq_deleg(hi), .mstat_in(msi), .hstat_in(hsi),
    .trap_taken(a_tk), .trap_mode(a_md), .virt_next(a_vn), .force_hs_next(a_fn),
    .swap_strobe(a_sw), .cause_out(a_c), .mstat_out(a_ms), .hstat_out(a_hs));

  hv_trap_deleg #(.HV(1'b0)) u_hv_trap_deleg_flat (
    .clk(clk), .rst_n(rst_n), .trap_valid(tv), .trap_async(ta), .trap_cause(tc),
    .cur_priv(pr), .virt_on(vo), .force_hs(fh), .m_exc_deleg(me), .m_irq_deleg(mi),
    .h_exc_deleg(he), .h_irq_deleg(hi), .mstat_in(msi), .hstat_in(hsi),
    .trap_taken(b_tk), .trap_mode(b_md), .virt_next(b_vn), .force_hs_next(b_fn),
    .swap_strobe(b_sw), .cause_out(b_c), .mstat_out(b_ms), .hstat_out(b_hs));

  assign out_a = {a_tk, a_md, a_vn, a_fn, a_sw, a_c, a_ms, a_hs};
  assign out_b = {b_tk, b_md, b_vn, b_fn, b_sw, b_c, b_ms, b_hs};

  // Expected result vector {taken, mode, virt, force, swap, cause, mstat, hstat}
  function automatic logic [24:0] model(bit hv);
    logic [5:0] c2;
    logic [31:0] dm, dh;
    logic sl, vs, vn, fn, sw;
    logic [1:0] mode;
    logic [8:0] m;
    logic [3:0] h;
    c2 = tc;
    if (!ta && tc == 6'd8) c2 = (pr == 2'd3) ? 6'd11 : (pr == 2'd1) ? (vo ? 6'd10 : 6'd9) : 6'd8;
    dm = ta ? mi : me;
    dh = ta ? hi : he;
    sl = (pr <= 2'd1) && (c2 < 6'd32) && dm[c2[4:0]];
    vs = hv && sl && vo && dh[c2[4:0]] && !fh;
    m = msi; h = hsi; vn = vo; fn = fh; sw = 1'b0;
    if (sl) begin
      mode = 2'd1; m[2] = msi[0]; m[4] = pr[0]; m[0] = 1'b0;
      if (!vs) begin
        h[1] = hsi[0]; h[2] = msi[4]; h[0] = vo;
        if (vo) begin sw = 1'b1; h[3] = fh; fn = 1'b0; end
        vn = 1'b0;
      end
    end else begin
      mode = 2'd3; m[3] = msi[1]; m[6:5] = pr; m[1] = 1'b0;
      m[7] = vo; m[8] = fh; sw = vo; vn = 1'b0;
    end
    if (!hv) begin h = '0; m[8:7] = 2'b00; vn = 1'b0; fn = 1'b0; sw = 1'b0; end
    return {1'b1, mode, vn, fn, sw, c2, m, h};
  endfunction

  function automatic string tag_of();
    logic [31:0] dm, dh;
    logic [5:0] c2;
    c2 = tc;
    if (!ta && tc == 6'd8) return "R1";
    dm = ta ? mi : me;
    dh = ta ? hi : he;
    if (!((pr <= 2'd1) && (c2 < 6'd32) && dm[c2[4:0]])) return "R6";
    if (vo && dh[c2[4:0]] && !fh) return "R3";
    return vo ? "R4" : "R5";
  endfunction

  task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one trap on a falling edge; results due after the next rising edge.
  task automatic trap_and_check();
    logic [24:0] ea, eb;
    string t;
    tv = 1'b1;
    ea = model(1'b1);
    eb = model(1'b0);
    t = tag_of();
    @(negedge clk);
    check({t, " R2 R7 R8"}, out_a, ea);
    check("R10", out_b, eb);
    tv = 1'b0;
    ta = $urandom_range(0, 1); tc = 6'($urandom_range(0, 40));
    vo = $urandom_range(0, 1); msi = 9'($urandom);
    @(negedge clk);
    check("R8 hold", out_a, {1'b0, ea[23:20], 1'b0, ea[18:0]});
    check("R8 hold R10", out_b, {1'b0, eb[23:20], 1'b0, eb[18:0]});
  endtask

  task automatic setup(bit a, int c, int p, bit v, bit f, logic [31:0] d);
    ta = a; tc = 6'(c); pr = 2'(p); vo = v; fh = f;
    me = d; mi = d; he = d; hi = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", out_a, {1'b0, 2'd3, 22'd0});
    check("R9", out_b, {1'b0, 2'd3, 22'd0});
    msi = 9'h0FF; hsi = 4'b0101;
    // R1 environment call renaming from each mode
    setup(0, 8, 0, 0, 0, '0); trap_and_check();
    setup(0, 8, 1, 0, 0, '0); trap_and_check();
    setup(0, 8, 1, 1, 0, '0); trap_and_check();
    setup(0, 8, 3, 0, 0, '1); trap_and_check();
    setup(1, 8, 1, 1, 0, '1); trap_and_check();
    // R3 stays in guest; R4 guest to HS with force; R5 HS to HS keeps stl
    setup(0, 13, 1, 1, 0, '1); trap_and_check();
    setup(0, 13, 0, 1, 1, '1); trap_and_check();
    setup(1, 5, 1, 0, 1, '1); trap_and_check();
    // R2 cause beyond XLEN and M-mode origin go to M; R6 swap from guest
    setup(0, 40, 0, 1, 1, '1); trap_and_check();
    setup(0, 2, 3, 0, 0, '1); trap_and_check();
    setup(1, 7, 0, 1, 1, 32'h0); trap_and_check();
    setup(0, 3, 1, 1, 0, 32'h0000_0008); he = '0; trap_and_check();
    for (int i = 0; i < 400; i++) begin
      ta = $urandom_range(0, 1);
      tc = ($urandom_range(0, 3) == 0) ? 6'd8 : 6'($urandom_range(0, 40));
      pr = 2'($urandom_range(0, 3));
      vo = $urandom_range(0, 1); fh = $urandom_range(0, 1);
      me = $urandom; mi = $urandom; he = $urandom; hi = $urandom;
      msi = 9'($urandom); hsi = 4'($urandom);
      trap_and_check();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule